// File: doc/BRIEF.md
# Decimal Coefficient Alignment Unit

This unit prepares two unpacked decimal operands for a later add or subtract stage. Each operand is a 16-digit BCD coefficient with a 10-bit biased exponent. Decimal coefficients are held as unnormalized integers, so each one is first pushed to the left until its top digit is nonzero. That operand's exponent drops by the number of digit positions moved, and it never drops below zero.

The two normalized operands are then ordered by exponent. The larger-exponent coefficient passes through unchanged. The smaller one is extended by two low digit positions, for guard and round, and shifted right by whole digits until both operands share the larger exponent. The shift saturates at 18 digits. Any nonzero digit that falls off the bottom of the 18-digit field raises a sticky flag, which the rounding logic downstream consumes.

All outputs are produced together. They come either straight from the combinational path or, by default, from one output register stage. Decoding of the packed format, the digit addition and rounding belong to other blocks.

Top module: `dec_align`

## Requirements
- R1: A nonzero coefficient is shifted left by its count of leading zero digits, and its exponent is reduced by the same count.
- R2: The left shift of R1 is limited to the operand's exponent value. The temporary exponent therefore never goes below 0, and the coefficient may stay partly unnormalized with temporary exponent 0.
- R3: A zero coefficient passes normalization unchanged with its exponent unmodified. Its zero flag is set: a_zero_o for the operand placed first, b_zero_o for the operand placed second.
- R4: If the first operand's temporary exponent is strictly less than the second's, the operands are exchanged and swap_o is 1. On equal exponents swap_o is 0. a_coef_o holds the larger-exponent coefficient and exp_o holds the larger temporary exponent.
- R5: b_coef_o is 18 digits wide. It equals the smaller-exponent coefficient with two zero digits appended below it, shifted right by min(exponent difference, 18) digits. Digit 1 (bits 7:4) is the guard digit and digit 0 (bits 3:0) is the round digit.
- R6: sticky_o is 1 exactly when a nonzero digit is shifted below digit 0 of b_coef_o. A shift that saturates at 18 with a nonzero coefficient gives b_coef_o = 0 and sticky_o = 1.
- R7: With OUT_REG=1 every output is registered one clock after its inputs, and all outputs are 0 while rst_ni is low. With OUT_REG=0 the outputs follow the inputs combinationally.
- R8: When every input digit is a valid BCD digit (0 to 9), every output digit is also a valid BCD digit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the output stage |
| rst_ni | input | 1 | Active-low asynchronous reset |
| op_a_coef_i | input | 64 | First operand coefficient, 16 BCD digits |
| op_a_exp_i | input | 10 | First operand biased exponent |
| op_b_coef_i | input | 64 | Second operand coefficient, 16 BCD digits |
| op_b_exp_i | input | 10 | Second operand biased exponent |
| a_coef_o | output | 64 | Normalized coefficient with the larger exponent |
| b_coef_o | output | 72 | Aligned coefficient with guard and round digits |
| exp_o | output | 10 | Common exponent after alignment |
| swap_o | output | 1 | Operands were exchanged |
| sticky_o | output | 1 | Nonzero digits lost below the aligned field |
| a_zero_o | output | 1 | Coefficient on a_coef_o is zero |
| b_zero_o | output | 1 | Coefficient aligned into b_coef_o is zero |

## Verification
The assertions assume that every input digit is a legal BCD value. The digit-validity property and the clamp property both rely on this. The bench drives only hand-chosen coefficients made of digits 0 to 9, and it loads the inputs with zero before reset releases. Exponents are unconstrained: the stimulus covers exponent 0, differences of 0 to 2, differences just below and at the 18-digit limit, and differences of several hundred.

// File: rtl/dec_align_pkg.sv
package dec_align_pkg;
  localparam int unsigned DIGIT_W = 4;

  function automatic logic digit_ok(input logic [DIGIT_W-1:0] d);
    return d <= 4'd9;
  endfunction
endpackage

// File: rtl/dec_lzd_norm.sv
module dec_lzd_norm
  import dec_align_pkg::*;
#(
  parameter int unsigned NDIG  = 16,
  parameter int unsigned EXP_W = 10,
  localparam int unsigned CB   = NDIG * DIGIT_W,
  localparam int unsigned CW   = $clog2(NDIG + 1)
) (
  input  logic [CB-1:0]    coef_i,
  input  logic [EXP_W-1:0] exp_i,
  output logic [CB-1:0]    coef_o,
  output logic [EXP_W-1:0] exp_o,
  output logic             zero_o
);
  logic [CW-1:0] lz;
  logic [CW-1:0] shamt;
  logic          hit;

  // priority scan from the top digit
  always_comb begin
    lz  = '0;
    hit = 1'b0;
    for (int i = NDIG - 1; i >= 0; i--) begin
      if (!hit) begin
        if (coef_i[i*DIGIT_W +: DIGIT_W] != '0) hit = 1'b1;
        else lz = lz + 1'b1;
      end
    end
  end

  // shift never drives the exponent below zero
  always_comb begin
    if (!hit)                     shamt = '0;
    else if (exp_i < EXP_W'(lz))  shamt = exp_i[CW-1:0];
    else                          shamt = lz;
  end

  assign coef_o = coef_i << (shamt * DIGIT_W);
  assign exp_o  = exp_i - EXP_W'(shamt);
  assign zero_o = !hit;
endmodule

// File: rtl/dec_order.sv
module dec_order
  import dec_align_pkg::*;
#(
  parameter int unsigned NDIG  = 16,
  parameter int unsigned EXP_W = 10,
  parameter int unsigned MAXSH = 18,
  localparam int unsigned CB   = NDIG * DIGIT_W,
  localparam int unsigned RW   = $clog2(MAXSH + 1)
) (
  input  logic [CB-1:0]    a_coef_i,
  input  logic [EXP_W-1:0] a_exp_i,
  input  logic             a_zero_i,
  input  logic [CB-1:0]    b_coef_i,
  input  logic [EXP_W-1:0] b_exp_i,
  input  logic             b_zero_i,
  output logic [CB-1:0]    hi_coef_o,
  output logic [CB-1:0]    lo_coef_o,
  output logic [EXP_W-1:0] hi_exp_o,
  output logic             hi_zero_o,
  output logic             lo_zero_o,
  output logic             swap_o,
  output logic [RW-1:0]    rsa_o
);
  logic [EXP_W-1:0] lo_exp;
  logic [EXP_W-1:0] diff;

  assign swap_o = a_exp_i < b_exp_i;

  always_comb begin
    if (swap_o) begin
      hi_coef_o = b_coef_i;  hi_exp_o = b_exp_i;  hi_zero_o = b_zero_i;
      lo_coef_o = a_coef_i;  lo_exp   = a_exp_i;  lo_zero_o = a_zero_i;
    end else begin
      hi_coef_o = a_coef_i;  hi_exp_o = a_exp_i;  hi_zero_o = a_zero_i;
      lo_coef_o = b_coef_i;  lo_exp   = b_exp_i;  lo_zero_o = b_zero_i;
    end
  end

  assign diff  = hi_exp_o - lo_exp;
  assign rsa_o = (diff > EXP_W'(MAXSH)) ? RW'(MAXSH) : diff[RW-1:0];
endmodule

// File: rtl/dec_rshift.sv
module dec_rshift
  import dec_align_pkg::*;
#(
  parameter int unsigned NDIG = 16,
  parameter int unsigned XDIG = 2,
  parameter int unsigned RW   = 5,
  localparam int unsigned CB  = NDIG * DIGIT_W,
  localparam int unsigned XB  = (NDIG + XDIG) * DIGIT_W
) (
  input  logic [CB-1:0] coef_i,
  input  logic [RW-1:0] rsa_i,
  output logic [XB-1:0] coef_o,
  output logic          sticky_o
);
  logic [2*XB-1:0] wide;

  // lower half collects every digit pushed out of the field
  assign wide     = {coef_i, {(XDIG*DIGIT_W){1'b0}}, {XB{1'b0}}} >> (rsa_i * DIGIT_W);
  assign coef_o   = wide[2*XB-1:XB];
  assign sticky_o = |wide[XB-1:0];
endmodule

// File: rtl/dec_align.sv
module dec_align
  import dec_align_pkg::*;
#(
  parameter int unsigned NDIG    = 16,
  parameter int unsigned EXP_W   = 10,
  parameter int unsigned XDIG    = 2,
  parameter bit          OUT_REG = 1'b1,
  localparam int unsigned CB     = NDIG * DIGIT_W,
  localparam int unsigned XB     = (NDIG + XDIG) * DIGIT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CB-1:0]    op_a_coef_i,
  input  logic [EXP_W-1:0] op_a_exp_i,
  input  logic [CB-1:0]    op_b_coef_i,
  input  logic [EXP_W-1:0] op_b_exp_i,
  output logic [CB-1:0]    a_coef_o,
  output logic [XB-1:0]    b_coef_o,
  output logic [EXP_W-1:0] exp_o,
  output logic             swap_o,
  output logic             sticky_o,
  output logic             a_zero_o,
  output logic             b_zero_o
);
  localparam int unsigned MAXSH = NDIG + XDIG;
  localparam int unsigned RW    = $clog2(MAXSH + 1);

  logic [CB-1:0]    in_coef [2];
  logic [EXP_W-1:0] in_exp  [2];
  logic [CB-1:0]    n_coef  [2];
  logic [EXP_W-1:0] n_exp   [2];
  logic             n_zero  [2];

  assign in_coef[0] = op_a_coef_i;
  assign in_coef[1] = op_b_coef_i;
  assign in_exp[0]  = op_a_exp_i;
  assign in_exp[1]  = op_b_exp_i;

  for (genvar g = 0; g < 2; g++) begin : g_norm
    dec_lzd_norm #(.NDIG(NDIG), .EXP_W(EXP_W)) u_norm (
      .coef_i (in_coef[g]),
      .exp_i  (in_exp[g]),
      .coef_o (n_coef[g]),
      .exp_o  (n_exp[g]),
      .zero_o (n_zero[g])
    );
  end

  logic [CB-1:0]    hi_coef, lo_coef;
  logic [EXP_W-1:0] hi_exp;
  logic             hi_zero, lo_zero, swp;
  logic [RW-1:0]    rsa;

  dec_order #(.NDIG(NDIG), .EXP_W(EXP_W), .MAXSH(MAXSH)) u_order (
    .a_coef_i  (n_coef[0]),
    .a_exp_i   (n_exp[0]),
    .a_zero_i  (n_zero[0]),
    .b_coef_i  (n_coef[1]),
    .b_exp_i   (n_exp[1]),
    .b_zero_i  (n_zero[1]),
    .hi_coef_o (hi_coef),
    .lo_coef_o (lo_coef),
    .hi_exp_o  (hi_exp),
    .hi_zero_o (hi_zero),
    .lo_zero_o (lo_zero),
    .swap_o    (swp),
    .rsa_o     (rsa)
  );

  logic [XB-1:0] al_coef;
  logic          al_sticky;

  dec_rshift #(.NDIG(NDIG), .XDIG(XDIG), .RW(RW)) u_shift (
    .coef_i   (lo_coef),
    .rsa_i    (rsa),
    .coef_o   (al_coef),
    .sticky_o (al_sticky)
  );

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        a_coef_o <= '0;
        b_coef_o <= '0;
        exp_o    <= '0;
        swap_o   <= 1'b0;
        sticky_o <= 1'b0;
        a_zero_o <= 1'b0;
        b_zero_o <= 1'b0;
      end else begin
        a_coef_o <= hi_coef;
        b_coef_o <= al_coef;
        exp_o    <= hi_exp;
        swap_o   <= swp;
        sticky_o <= al_sticky;
        a_zero_o <= hi_zero;
        b_zero_o <= lo_zero;
      end
    end
  end else begin : g_comb
    assign a_coef_o = hi_coef;
    assign b_coef_o = al_coef;
    assign exp_o    = hi_exp;
    assign swap_o   = swp;
    assign sticky_o = al_sticky;
    assign a_zero_o = hi_zero;
    assign b_zero_o = lo_zero;
  end
endmodule

// File: rtl/dec_align_chk.sv
module dec_align_chk
  import dec_align_pkg::*;
#(
  parameter int unsigned NDIG  = 16,
  parameter int unsigned EXP_W = 10,
  parameter int unsigned XDIG  = 2,
  localparam int unsigned CB   = NDIG * DIGIT_W,
  localparam int unsigned XB   = (NDIG + XDIG) * DIGIT_W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [CB-1:0]    a_coef_o,
  input logic [XB-1:0]    b_coef_o,
  input logic [EXP_W-1:0] exp_o,
  input logic             sticky_o,
  input logic             a_zero_o,
  input logic             b_zero_o
);
  function automatic logic all_bcd(input logic [XB-1:0] v);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < NDIG + XDIG; i++)
      if (!digit_ok(v[i*DIGIT_W +: DIGIT_W])) ok = 1'b0;
    return ok;
  endfunction

  // R2: an unnormalized nonzero leader can only sit at exponent 0
  p_clamp_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!a_zero_o && a_coef_o[CB-1 -: DIGIT_W] == '0) |-> exp_o == '0);

  p_zero_a_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a_zero_o |-> a_coef_o == '0);

  p_zero_b_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    b_zero_o |-> (b_coef_o == '0 && !sticky_o));

  // R6: loss needs a shift past both extra digits, so the top three digits are empty
  p_sticky_shift_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sticky_o |-> b_coef_o[XB-1 -: 3*DIGIT_W] == '0);

  p_bcd_out_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    all_bcd({{(XB-CB){1'b0}}, a_coef_o}) && all_bcd(b_coef_o));
endmodule

bind dec_align dec_align_chk #(.NDIG(NDIG), .EXP_W(EXP_W), .XDIG(XDIG)) u_chk (.*);

// File: tb/sim_dec_align.sv
`timescale 1ns/1ps
module sim_dec_align;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [63:0] op_a_coef_i = '0;
  logic [9:0]  op_a_exp_i = '0;
  logic [63:0] op_b_coef_i = '0;
  logic [9:0]  op_b_exp_i = '0;
  logic [63:0] a_coef_o;
  logic [71:0] b_coef_o;
  logic [9:0]  exp_o;
  logic        swap_o, sticky_o, a_zero_o, b_zero_o;

  dec_align u0 (.*);

  always #2.5 clk_i = ~clk_i;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [63:0] e_a;
  logic [71:0] e_b;
  logic [9:0]  e_exp;
  logic        e_swap, e_sticky, e_az, e_bz;

  task automatic chk(input string req, input string what, input logic [71:0] act, input logic [71:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic norm(inout logic [63:0] c, inout logic [9:0] e, output logic z);
    z = (c == '0);
    for (int i = 0; i < 16; i++)
      if (c != '0 && c[63:60] == 4'h0 && e != '0) begin
        c = c << 4;
        e = e - 10'd1;
      end
  endtask

  task automatic model(input logic [63:0] ac, input logic [9:0] ae, input logic [63:0] bc, input logic [9:0] be);
    logic za, zb;
    logic [9:0] d;
    logic [71:0] x;
    int sh;
    norm(ac, ae, za);
    norm(bc, be, zb);
    e_swap = ae < be;
    if (e_swap) begin
      e_a = bc; e_exp = be; e_az = zb; x = {ac, 8'h00}; e_bz = za; d = be - ae;
    end else begin
      e_a = ac; e_exp = ae; e_az = za; x = {bc, 8'h00}; e_bz = zb; d = ae - be;
    end
    sh = (d > 10'd18) ? 18 : int'(d);
    e_sticky = 1'b0;
    for (int i = 0; i < sh; i++) begin
      if (x[3:0] != 4'h0) e_sticky = 1'b1;
      x = x >> 4;
    end
    e_b = x;
  endtask

  task automatic chk_all(input string req);
    logic bad;
    chk(req, "a_coef", {8'h00, a_coef_o}, {8'h00, e_a});
    chk(req, "b_coef", b_coef_o, e_b);
    chk(req, "exp", {62'd0, exp_o}, {62'd0, e_exp});
    chk(req, "swap", {71'd0, swap_o}, {71'd0, e_swap});
    chk(req, "sticky", {71'd0, sticky_o}, {71'd0, e_sticky});
    chk(req, "a_zero", {71'd0, a_zero_o}, {71'd0, e_az});
    chk(req, "b_zero", {71'd0, b_zero_o}, {71'd0, e_bz});
    bad = 1'b0;
    for (int i = 0; i < 16; i++) if (a_coef_o[i*4 +: 4] > 4'd9) bad = 1'b1;
    for (int i = 0; i < 18; i++) if (b_coef_o[i*4 +: 4] > 4'd9) bad = 1'b1;
    chk("R8", "bcd_digits", {71'd0, bad}, 72'd0);
  endtask

  task automatic apply(input logic [63:0] ac, input logic [9:0] ae, input logic [63:0] bc, input logic [9:0] be);
    @(negedge clk_i);
    op_a_coef_i = ac; op_a_exp_i = ae; op_b_coef_i = bc; op_b_exp_i = be;
    model(ac, ae, bc, be);
    @(negedge clk_i);
  endtask

  task automatic t_reset_r7();
    op_a_coef_i = 64'h1234_0000_0000_0000; op_a_exp_i = 10'd9;
    op_b_coef_i = 64'h5; op_b_exp_i = 10'd3;
    repeat (3) @(negedge clk_i);
    chk("R7", "reset a_coef", {8'h00, a_coef_o}, 72'd0);
    chk("R7", "reset b_coef", b_coef_o, 72'd0);
    chk("R7", "reset flags", {62'd0, exp_o, swap_o, sticky_o}, 72'd0);
    op_a_coef_i = '0; op_b_coef_i = '0; op_a_exp_i = '0; op_b_exp_i = '0;
    rst_ni = 1'b1;
  endtask

  task automatic t_norm_r1();
    apply(64'h0000_0000_0000_1234, 10'd100, 64'h1000_0000_0000_0000, 10'd80);
    chk_all("R1");
    chk("R1", "hand a_coef", {8'h00, a_coef_o}, {8'h00, 64'h1234_0000_0000_0000});
    chk("R1", "hand exp", {62'd0, exp_o}, 72'd88);
    chk("R5", "hand b_coef", b_coef_o, 72'h10_0000_0000);
    apply(64'h0000_0000_0000_0001, 10'd20, 64'h0000_0000_0000_0000, 10'd1);
    chk("R1", "hand digit0 a_coef", {8'h00, a_coef_o}, {8'h00, 64'h1000_0000_0000_0000});
    chk("R1", "hand digit0 exp", {62'd0, exp_o}, 72'd5);
  endtask

  task automatic t_clamp_r2();
    apply(64'h0000_0000_0012_3456, 10'd3, 64'h0000_0000_0000_0007, 10'd0);
    chk_all("R2");
    chk("R2", "hand a_coef", {8'h00, a_coef_o}, {8'h00, 64'h0000_0001_2345_6000});
    chk("R2", "hand exp", {62'd0, exp_o}, 72'd0);
    chk("R2", "hand b_coef", b_coef_o, 72'h700);
  endtask

  task automatic t_zero_r3();
    apply(64'h0, 10'd50, 64'h9, 10'd40);
    chk_all("R3");
    chk("R3", "zero keeps exp", {62'd0, exp_o}, 72'd50);
    chk("R3", "a_zero", {71'd0, a_zero_o}, 72'd1);
    apply(64'h0, 10'd5, 64'h0, 10'd900);
    chk_all("R3");
    chk("R3", "both zero b_zero", {71'd0, b_zero_o}, 72'd1);
  endtask

  task automatic t_swap_r4();
    apply(64'h1, 10'd10, 64'h5000_0000_0000_0000, 10'd2);
    chk_all("R4");
    chk("R4", "swap set", {71'd0, swap_o}, 72'd1);
    chk("R4", "hand b_coef", b_coef_o, 72'h100_0000_0000);
    apply(64'h3000_0000_0000_0000, 10'd7, 64'h4000_0000_0000_0000, 10'd7);
    chk_all("R4");
    chk("R4", "equal no swap", {71'd0, swap_o}, 72'd0);
    apply(64'h0000_0000_0000_0042, 10'd300, 64'h0000_0000_0007_0000, 10'd301);
    chk_all("R4");
  endtask

  task automatic t_guard_round_r5();
    apply(64'h1111_1111_1111_1111, 10'd500, 64'h9876_5432_1098_7654, 10'd498);
    chk_all("R5");
    chk("R5", "guard round diff2", b_coef_o, 72'h00_9876_5432_1098_7654);
    apply(64'h1111_1111_1111_1111, 10'd500, 64'h9876_5432_1098_7654, 10'd499);
    chk("R5", "diff1", b_coef_o, 72'h0_9876_5432_1098_7654_0);
    apply(64'h2222_2222_2222_2222, 10'd64, 64'h8765_4321_0987_6543, 10'd64);
    chk_all("R5");
  endtask

  task automatic t_sticky_r6();
    apply(64'h1111_1111_1111_1111, 10'd200, 64'h1234_5678_9012_3454, 10'd197);
    chk_all("R6");
    chk("R6", "lost digit 4", {71'd0, sticky_o}, 72'd1);
    apply(64'h1111_1111_1111_1111, 10'd200, 64'h1234_5678_9012_3450, 10'd197);
    chk("R6", "lost digit 0", {71'd0, sticky_o}, 72'd0);
    apply(64'h1111_1111_1111_1111, 10'd200, 64'h1234_5678_9012_3450, 10'd196);
    chk("R6", "lost 50", {71'd0, sticky_o}, 72'd1);
    apply(64'h1111_1111_1111_1111, 10'd200, 64'h9000_0000_0000_0000, 10'd183);
    chk_all("R6");
    chk("R6", "diff17 keeps top", b_coef_o, 72'h9);
    apply(64'h1111_1111_1111_1111, 10'd200, 64'h9000_0000_0000_0000, 10'd182);
    chk("R6", "diff18 b zero", b_coef_o, 72'd0);
    chk("R6", "diff18 sticky", {71'd0, sticky_o}, 72'd1);
    apply(64'h5000_0000_0000_0000, 10'd900, 64'h1000_0000_0000_0001, 10'd100);
    chk_all("R6");
  endtask

  task automatic t_latency_r7();
    apply(64'h7000_0000_0000_0000, 10'd40, 64'h6000_0000_0000_0000, 10'd39);
    chk_all("R7");
    @(negedge clk_i);
    op_a_coef_i = 64'h0000_0000_0000_0003; op_a_exp_i = 10'd600;
    op_b_coef_i = 64'h0000_0000_0000_0002; op_b_exp_i = 10'd700;
    #1;
    chk("R7", "held before edge a_coef", {8'h00, a_coef_o}, {8'h00, e_a});
    chk("R7", "held before edge exp", {62'd0, exp_o}, {62'd0, e_exp});
    model(op_a_coef_i, op_a_exp_i, op_b_coef_i, op_b_exp_i);
    @(negedge clk_i);
    chk_all("R7");
  endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R7 watchdog actual=timeout expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset_r7();
    t_norm_r1();
    t_clamp_r2();
    t_zero_r3();
    t_swap_r4();
    t_guard_round_r5();
    t_sticky_r6();
    t_latency_r7();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule